// File: doc/BRIEF.md
# GPIO and Control Register Bank

This block is a small register bank on a word-addressed register bus. It serves sixteen general-purpose lines. It holds a set of plain control and interrupt-bookkeeping words, a read-only status word, a power word with a forcing rule, a direction register and a level register. The level register can be written through either of two aliased offsets. The sixteen output pins carry the level masked by the direction. Whenever a direction or level write changes a driven pin, that pin's toggle strobe is raised for exactly one cycle. The block does not compute interrupts from the bookkeeping words; it only stores them.

Sixteen input lines act on the level register through edges. When an input line changes, its level bit takes the new value of the line. This change does not re-drive the outputs. The masked level appears on the pins only at the next direction or level write.

A request is presented for one cycle with `req_valid` high. The block registers the read data and the write error flag on the clock edge that accepts the request. Pin updates follow one cycle later.

Top module: `gpx_regbank`

## Requirements
- R1: After reset every register reads 0 except the status word, which reads 0x0002. The outputs `pin_out`, `pin_toggle` and `bus_err` are 0.
- R2: The byte offsets are decoded exactly: 0x00 mode, 0x04 config, 0x08 status, 0x0C power, 0x10 clock control, 0x14 raw interrupt, 0x18 interrupt mask, 0x1C interrupt state, 0x20 direction, 0x24 and 0x28 level. Read data appears on `rsp_rdata` in the cycle after the request and is held until the next read.
- R3: The words at 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back the last value written to them.
- R4: A write to 0x0C stores the written value. If bit 7 of that value is 1, bits 15 and 6 are also set in the stored word.
- R5: A write to 0x08 raises no error and leaves the status word at 0x0002.
- R6: A write to 0x24 or 0x28 stores the written value ANDed with the direction register into the level register. A read of either offset returns the level register.
- R7: Two cycles after a write to 0x20, 0x24 or 0x28, `pin_out` equals level AND direction. In that same cycle `pin_toggle` is high for one cycle on each bit that differs from the previous `pin_out`. At all other times `pin_toggle` is 0.
- R8: A change on an input line copies the new line value into its level bit. The change does not alter `pin_out` until the next direction or level write.
- R9: If a level write and an input-line change fall in the same cycle, the bus write decides the whole level register.
- R10: A read of any other offset, including offsets that are not word aligned, returns 0. A write to such an offset changes no register and raises `bus_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a write to an undefined offset |
| pin_in | input | 16 | External input lines |
| pin_out | output | 16 | Driven lines (level AND direction) |
| pin_toggle | output | 16 | One-cycle strobe per driven line that changed |

## Verification
Read data and the error flag come from the clock edge that accepts the request, so they are due one cycle after it. The pins and toggle strobes go through one more register and are due two cycles after a direction or level write. An input edge is visible to a read issued in the next cycle. The driver stamps each expected item with the exact cycle in which it is due. The monitor compares an item only in that cycle, and an item left unchecked at the end counts as a miscompare. Extra immediate checks after idle cycles confirm that the toggle strobes have dropped and that input edges did not move the pins.

// File: rtl/gpx_pkg.sv
// Shared constants and types for the GPIO register bank.
// Assumes a 6-bit byte offset and 16-bit data words.
package gpx_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int NLINES = 16;

    localparam logic [DATA_W-1:0] STAT_RESET  = 16'h0002;
    localparam logic [DATA_W-1:0] PWR_FORCE   = 16'h8040;
    localparam int                PWR_TRIGGER = 7;

    localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_PWR   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_CLK   = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_IRAW  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IMSK  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_LVLW  = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_LVLR  = 6'h28;

    typedef enum logic [3:0] {
        SEL_MODE, SEL_CFG, SEL_STAT, SEL_PWR, SEL_CLK, SEL_IRAW,
        SEL_IMSK, SEL_ISTAT, SEL_DIR, SEL_LVL, SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/gpx_decode.sv
// Offset decoder: maps a byte offset onto a register selector.
// Assumes an exact match; any other offset selects SEL_NONE.
module gpx_decode
    import gpx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Purpose: exact-match decode of the offset.
    always_comb begin
        case (addr)
            OFF_MODE:           sel = SEL_MODE;
            OFF_CFG:            sel = SEL_CFG;
            OFF_STAT:           sel = SEL_STAT;
            OFF_PWR:            sel = SEL_PWR;
            OFF_CLK:            sel = SEL_CLK;
            OFF_IRAW:           sel = SEL_IRAW;
            OFF_IMSK:           sel = SEL_IMSK;
            OFF_ISTAT:          sel = SEL_ISTAT;
            OFF_DIR:            sel = SEL_DIR;
            OFF_LVLW, OFF_LVLR: sel = SEL_LVL;
            default:            sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpx_pin_core.sv
// Direction and level storage for the GPIO lines.
// Input lines act on level bits only on edges. A bus level write is
// masked by the direction held before the write and overrides input edges.
// Emits a one-cycle re-evaluation pulse after any direction or level write.
module gpx_pin_core #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_lvl,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] dir_q,
    output logic [NLINES-1:0] lvl_q,
    output logic              reeval
);
    logic [NLINES-1:0] pin_prev;
    logic [NLINES-1:0] pin_edge;

    assign pin_edge = pin_in ^ pin_prev;

    // Purpose: direction register, input history and re-evaluation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            pin_prev <= '0;
            reeval   <= 1'b0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            pin_prev <= pin_in;
            reeval   <= wr_dir | wr_lvl;
        end
    end

    for (genvar b = 0; b < NLINES; b++) begin : g_lvl
        // Purpose: one level bit; a bus write wins over an input edge.
        always_ff @(posedge clk) begin
            if (!rst_n)           lvl_q[b] <= 1'b0;
            else if (wr_lvl)      lvl_q[b] <= wdata[b] & dir_q[b];
            else if (pin_edge[b]) lvl_q[b] <= pin_in[b];
        end
    end
endmodule

// File: rtl/gpx_drive.sv
// Output driver: on a re-evaluation pulse it drives level AND direction
// and strobes for one cycle each line whose driven value changed.
module gpx_drive #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reeval,
    input  logic [NLINES-1:0] dir_q,
    input  logic [NLINES-1:0] lvl_q,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_toggle
);
    logic [NLINES-1:0] masked;

    assign masked = lvl_q & dir_q;

    // Purpose: update the driven vector and the one-cycle change strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out    <= '0;
            pin_toggle <= '0;
        end else if (reeval) begin
            pin_toggle <= masked ^ pin_out;
            pin_out    <= masked;
        end else begin
            pin_toggle <= '0;
        end
    end
endmodule

// File: rtl/gpx_regbank.sv
// GPIO and control register bank, top level.
// Single-cycle request; read data and error flag registered one cycle
// later. Assumes NLINES <= DATA_W; GPIO words are zero-extended on read.
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NL = NLINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_err,
    input  logic [NL-1:0] pin_in,
    output logic [NL-1:0] pin_out,
    output logic [NL-1:0] pin_toggle
);
    reg_sel_e      sel;
    logic          wr, rd;
    logic [DW-1:0] mode_q, cfg_q, pwr_q, clk_q, iraw_q, imsk_q, istat_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] pwr_next;
    logic [NL-1:0] dir_q, lvl_q;
    logic          reeval;

    assign wr = req_valid & req_write;
    assign rd = req_valid & ~req_write;

    gpx_decode u_dec (.addr(req_addr), .sel(sel));

    gpx_pin_core #(.NLINES(NL)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr && sel == SEL_DIR), .wr_lvl(wr && sel == SEL_LVL),
        .wdata(req_wdata[NL-1:0]), .pin_in(pin_in),
        .dir_q(dir_q), .lvl_q(lvl_q), .reeval(reeval)
    );

    gpx_drive #(.NLINES(NL)) u_drv (
        .clk(clk), .rst_n(rst_n), .reeval(reeval),
        .dir_q(dir_q), .lvl_q(lvl_q),
        .pin_out(pin_out), .pin_toggle(pin_toggle)
    );

    // Purpose: power word with the forced bits applied.
    always_comb begin
        pwr_next = req_wdata;
        if (req_wdata[PWR_TRIGGER]) pwr_next = req_wdata | PWR_FORCE;
    end

    // Purpose: plain control and bookkeeping words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; cfg_q <= '0; pwr_q <= '0; clk_q <= '0;
            iraw_q <= '0; imsk_q <= '0; istat_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_MODE:  mode_q  <= req_wdata;
                SEL_CFG:   cfg_q   <= req_wdata;
                SEL_PWR:   pwr_q   <= pwr_next;
                SEL_CLK:   clk_q   <= req_wdata;
                SEL_IRAW:  iraw_q  <= req_wdata;
                SEL_IMSK:  imsk_q  <= req_wdata;
                SEL_ISTAT: istat_q <= req_wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: read multiplexer; undefined offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_MODE:  rd_mux = mode_q;
            SEL_CFG:   rd_mux = cfg_q;
            SEL_STAT:  rd_mux = STAT_RESET;
            SEL_PWR:   rd_mux = pwr_q;
            SEL_CLK:   rd_mux = clk_q;
            SEL_IRAW:  rd_mux = iraw_q;
            SEL_IMSK:  rd_mux = imsk_q;
            SEL_ISTAT: rd_mux = istat_q;
            SEL_DIR:   rd_mux[NL-1:0] = dir_q;
            SEL_LVL:   rd_mux[NL-1:0] = lvl_q;
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: registered read data and write error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (rd) rsp_rdata <= rd_mux;
            bus_err <= wr && sel == SEL_NONE;
        end
    end
endmodule

// File: rtl/gpx_regbank_chk.sv
// Property checker for gpx_regbank, attached with bind.
module gpx_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [5:0]  req_addr,
    input logic [15:0] rsp_rdata,
    input logic        bus_err,
    input logic [15:0] pin_out,
    input logic [15:0] pin_toggle
);
    logic undef_off;
    logic gpio_wr;
    assign undef_off = (req_addr[1:0] != 2'b00) || (req_addr > 6'h28);
    assign gpio_wr   = req_valid && req_write &&
                       (req_addr == 6'h20 || req_addr == 6'h24 || req_addr == 6'h28);

    a_r10_err_on_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && undef_off) |=> bus_err);
    a_r10_no_err_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && undef_off) |=> !bus_err);
    a_r10_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && undef_off) |=> rsp_rdata == 16'h0000);
    a_r5_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 6'h08) |=> rsp_rdata == 16'h0002);
    a_r7_toggle_matches_change: assert property (@(posedge clk) disable iff (!rst_n)
        pin_toggle == (pin_out ^ $past(pin_out)));
    a_r8_pins_move_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(gpio_wr, 2));
endmodule

bind gpx_regbank gpx_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_rdata(rsp_rdata), .bus_err(bus_err),
    .pin_out(pin_out), .pin_toggle(pin_toggle)
);

// File: tb/gpx_regbank_test.sv
`timescale 1ns/1ps
module gpx_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0, pin_in = '0;
    logic [15:0] rsp_rdata, pin_out, pin_toggle;
    logic        bus_err;

    always #2.5 clk = ~clk;

    gpx_regbank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out), .pin_toggle(pin_toggle)
    );

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; int kind; logic [15:0] exp; string tag; } item_t;
    item_t sbq[$];

    // Bench model of the register contents.
    logic [15:0] m_mode = 0, m_cfg = 0, m_pwr = 0, m_clk = 0, m_iraw = 0;
    logic [15:0] m_imsk = 0, m_istat = 0, m_dir = 0, m_lvl = 0, m_out = 0, m_pins = 0;

    function automatic logic [15:0] mread(input logic [5:0] a);
        case (a)
            6'h00: return m_mode;  6'h04: return m_cfg;   6'h08: return 16'h0002;
            6'h0C: return m_pwr;   6'h10: return m_clk;   6'h14: return m_iraw;
            6'h18: return m_imsk;  6'h1C: return m_istat; 6'h20: return m_dir;
            6'h24, 6'h28: return m_lvl;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit undef(input logic [5:0] a);
        return a[1:0] != 0 || a > 6'h28;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int due, input int kind, input logic [15:0] exp, input string tag);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare items exactly in their due cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].due == cyc) begin
                    case (sbq[i].kind)
                        0: chk({sbq[i].tag, " rdata"}, rsp_rdata, sbq[i].exp);
                        1: chk({sbq[i].tag, " err"}, {15'b0, bus_err}, sbq[i].exp);
                        2: chk({sbq[i].tag, " pin_out"}, pin_out, sbq[i].exp);
                        default: chk({sbq[i].tag, " toggle"}, pin_toggle, sbq[i].exp);
                    endcase
                    sbq.delete(i);
                end
            end
        end
    end

    // Driver: one request (and pin value) per cycle, expectations pushed.
    task automatic bus(input logic w, input logic [5:0] a, input logic [15:0] d,
                       input logic [15:0] pins, input string tag);
        int c;
        logic [15:0] ev, nw;
        logic lvlwr, gp;
        c = cyc;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; pin_in = pins;
        ev = pins ^ m_pins; m_pins = pins;
        lvlwr = w && (a == 6'h24 || a == 6'h28);
        gp = w && (a == 6'h20 || lvlwr);
        if (!w) push(c + 1, 0, mread(a), tag);
        push(c + 1, 1, {15'b0, w && undef(a)}, tag);
        if (w) begin
            case (a)
                6'h00: m_mode = d;  6'h04: m_cfg = d;  6'h10: m_clk = d;
                6'h14: m_iraw = d;  6'h18: m_imsk = d; 6'h1C: m_istat = d;
                6'h0C: m_pwr = d[7] ? (d | 16'h8040) : d;
                6'h20: m_dir = d;
                6'h24, 6'h28: m_lvl = d & m_dir;
                default: ;
            endcase
        end
        if (!lvlwr) m_lvl = (m_lvl & ~ev) | (pins & ev);
        if (gp) begin
            nw = m_lvl & m_dir;
            push(c + 2, 2, nw, tag);
            push(c + 2, 3, nw ^ m_out, tag);
            m_out = nw;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
        bus(1'b1, a, d, m_pins, tag);
    endtask
    task automatic rd(input logic [5:0] a, input string tag);
        bus(1'b0, a, 16'h0, m_pins, tag);
    endtask
    task automatic set_pins(input logic [15:0] p);
        logic [15:0] ev;
        pin_in = p; ev = p ^ m_pins; m_pins = p;
        m_lvl = (m_lvl & ~ev) | (p & ev);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pin_out", pin_out, 16'h0);
        chk("R1 reset toggle", pin_toggle, 16'h0);
        chk("R1 reset err", {15'b0, bus_err}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2: reset values across the register window
        for (int a = 0; a <= 'h28; a += 4) rd(a[5:0], "R1");
        // R3: plain words read back
        wr(6'h00, 16'h1234, "R3"); wr(6'h04, 16'hBEEF, "R3"); wr(6'h10, 16'h0F0F, "R3");
        wr(6'h14, 16'h8001, "R3"); wr(6'h18, 16'h00FF, "R3"); wr(6'h1C, 16'hA5A5, "R3");
        rd(6'h00, "R3"); rd(6'h04, "R3"); rd(6'h10, "R3");
        rd(6'h14, "R3"); rd(6'h18, "R3"); rd(6'h1C, "R3");
        // R2: read data held while no read is issued
        repeat (2) @(negedge clk);
        chk("R2 rdata held", rsp_rdata, 16'hA5A5);
        // R4: power forcing
        wr(6'h0C, 16'h0081, "R4"); rd(6'h0C, "R4");
        wr(6'h0C, 16'h0012, "R4"); rd(6'h0C, "R4");
        wr(6'h0C, 16'h7F80, "R4"); rd(6'h0C, "R4");
        // R5: status write ignored
        wr(6'h08, 16'hFFFF, "R5"); rd(6'h08, "R5");
        // R6 / R7: masked level write, both aliases
        wr(6'h20, 16'h00FF, "R7 dir");
        wr(6'h24, 16'hA5A5, "R6"); rd(6'h28, "R6");
        wr(6'h28, 16'h0F0F, "R6"); rd(6'h24, "R6");
        repeat (3) @(negedge clk);
        chk("R7 toggle idle", pin_toggle, 16'h0);
        chk("R7 pin_out", pin_out, 16'h000F);
        // R8: input edges change level, not pins
        set_pins(16'h0100); rd(6'h24, "R8");
        set_pins(16'h0101); set_pins(16'h0100); rd(6'h24, "R8");
        repeat (2) @(negedge clk);
        chk("R8 pins unmoved", pin_out, 16'h000F);
        wr(6'h20, 16'h01FF, "R8 dir");
        repeat (3) @(negedge clk);
        chk("R8 pins after dir", pin_out, 16'h010E);
        // R9: bus write wins over a simultaneous input edge
        bus(1'b1, 6'h24, 16'h0000, 16'h0002, "R9"); rd(6'h28, "R9");
        wr(6'h20, 16'hFFFF, "R7 dir full"); wr(6'h24, 16'hFFFF, "R7 all");
        rd(6'h24, "R6");
        // R10: undefined offsets
        rd(6'h2C, "R10"); rd(6'h01, "R10"); rd(6'h3F, "R10");
        wr(6'h30, 16'hFFFF, "R10"); wr(6'h02, 16'h5555, "R10");
        rd(6'h00, "R10"); rd(6'h24, "R10");
        repeat (4) @(negedge clk);
        chk("R7 toggle final", pin_toggle, 16'h0);
        chk("R10 err cleared", {15'b0, bus_err}, 16'h0);
        n_chk++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule